// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller that sits beside an 8-bit successive-approximation converter. It picks one conversion-start source out of five, holds the analog track stage for one cycle, then walks an 8-step binary search from the most significant bit down. At each step it drives a trial code to the external DAC and reads back a single comparator bit. When the last bit is decided, the block latches the result, raises a sticky completion flag, and compares the result against a programmable window. A sticky window interrupt records a window hit.

Configuration is written through a small register-style port. Address 0 holds the control fields. Address 1 holds the channel and gain selects. Addresses 2 and 3 hold the upper and lower window limits. The channel select and the gain select are driven straight out to the analog multiplexer and the gain stage. Those analog parts are not inside this block.

The state machine has three states:
- `S_IDLE`: waiting for a trigger.
- `S_TRACK`: one tracking cycle.
- `S_CONV`: eight bit cycles, counted down by a bit index.

It has four transitions:
- trigger: `S_IDLE` to `S_TRACK`.
- track-done: `S_TRACK` to `S_CONV`, always taken.
- last-bit: `S_CONV` to `S_IDLE`, taken when the bit index is 0.
- shutdown: any state to `S_IDLE`, taken whenever the effective enable is 0.

Top module: `sar_seq_ctrl`

## Requirements
- R1: The configuration writes work as follows. Address 1 puts bits [2:0] on `chan_sel` and bits [5:3] on `gain_sel`. Address 2 sets the upper window limit and address 3 sets the lower limit. After reset, `chan_sel` is 0 and `gain_sel` is 3'b000, which is the half-gain code. The limits reset to upper 8'hFF and lower 8'h00.
- R2: Address 0 bit 0 is the enable, and `pwr_en` reflects it. While the enable is 0, every trigger is ignored. A write that clears the enable in the middle of a conversion aborts it: busy drops after that write, and `done` is not set.
- R3: The clock edge that accepts a trigger starts the conversion. For the next cycle `busy` and `track_en` are 1. Then comes one cycle with `dac_code` = 8'h80. `busy` stays 1 for exactly 9 cycles in total.
- R4: A comparator input of 1 means the analog input is at or above `dac_code`. The latched `result` is the largest code the comparator accepts. `result` changes only when a conversion completes.
- R5: A trigger that arrives while `busy` is 1 is ignored. It neither restarts nor extends the running conversion, and it does not queue another one.
- R6: `done` becomes 1 when a result is latched. It stays 1 until a write to address 0 with bit 5 set. A completion in the same cycle as the clear wins.
- R7: When lower ≤ upper, `win_irq` is set if lower ≤ result ≤ upper, with both limits inclusive.
- R8: When lower > upper, `win_irq` is set if result ≤ upper or result ≥ lower.
- R9: `win_irq` stays 1 until a write to address 0 with bit 6 set. A miss does not clear it.
- R10: Address 0 bits [3:1] select the start source:
  - 000: a write to address 0 with bit 4 set.
  - 001: a pulse on `tmr_a_ovf`.
  - 011: a pulse on `tmr_b_ovf`.
  - 1xx: a pulse on `peer_go`.
  Sources that are not selected are ignored.
- R11: In mode 010, `start_pin` passes through a two-flop synchroniser and starts a conversion on its rising edge. `busy` is first seen after the third clock edge following the rise. A level held high does not start another conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| tmr_a_ovf | input | 1 | First timer overflow pulse |
| tmr_b_ovf | input | 1 | Second timer overflow pulse |
| start_pin | input | 1 | Asynchronous external start pin |
| peer_go | input | 1 | Start pulse shared with a companion converter |
| cmp_in | input | 1 | Comparator output: input ≥ DAC code |
| pwr_en | output | 1 | Analog subsystem power enable |
| track_en | output | 1 | Track-and-hold tracking control |
| chan_sel | output | 3 | Analog multiplexer channel |
| gain_sel | output | 3 | Gain stage code |
| dac_code | output | 8 | Trial code to the DAC |
| result | output | 8 | Latched conversion result |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | Sticky conversion-complete flag |
| win_irq | output | 1 | Sticky window interrupt |

## Verification
The bench models the comparator from a target voltage code. The binary search is tried at three kinds of target:
- The extreme codes 0 and 255 expose errors in keeping or dropping the first and last bits.
- An alternating-bit code separates per-bit decision errors from shift errors.
- Random codes cover the rest.

The window is tried with random limits in both orderings. Directed cases are added at each limit and one step past it, which separates the inclusive and exclusive comparisons in both modes. Each start mode is driven both with its own source and with the sources it must ignore, so any swapped decode of the mode field shows up.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_TRACK = 2'd1,
        S_CONV  = 2'd2
    } sar_state_t;

    localparam logic [2:0] SRC_SOFT  = 3'b000;
    localparam logic [2:0] SRC_TMR_A = 3'b001;
    localparam logic [2:0] SRC_PIN   = 3'b010;
    localparam logic [2:0] SRC_TMR_B = 3'b011;

    localparam logic [2:0] GAIN_HALF = 3'b000;

endpackage

// File: rtl/sar_seq_trig.sv
module sar_seq_trig #(
    parameter int SYNC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [2:0] mode,
    input  logic       sw_go,
    input  logic       tmr_a,
    input  logic       tmr_b,
    input  logic       pin_async,
    input  logic       peer_go,
    output logic       trig
);

    logic [SYNC-1:0] sync_q;
    logic            pin_prev_q;
    logic            pin_rise;
    logic            src;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q     <= '0;
            pin_prev_q <= 1'b0;
        end else begin
            sync_q     <= {sync_q[SYNC-2:0], pin_async};
            pin_prev_q <= sync_q[SYNC-1];
        end
    end

    assign pin_rise = sync_q[SYNC-1] & ~pin_prev_q;

    always_comb begin
        if (mode[2]) begin
            src = peer_go;
        end else begin
            unique case (mode[1:0])
                2'b00:   src = sw_go;
                2'b01:   src = tmr_a;
                2'b10:   src = pin_rise;
                default: src = tmr_b;
            endcase
        end
    end

    assign trig = en & src;

    AST_TRIG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        trig |-> en); // R2

    AST_PIN_SYNCED: assert property (@(posedge clk) disable iff (!rst_n)
        pin_rise |-> $past(sync_q[SYNC-2])); // R11

endmodule

// File: rtl/sar_seq_win.sv
module sar_seq_win #(
    parameter int W = 8
) (
    input  logic [W-1:0] value,
    input  logic [W-1:0] upper,
    input  logic [W-1:0] lower,
    output logic         hit
);

    logic above_lo;
    logic below_hi;

    assign above_lo = (value >= lower);
    assign below_hi = (value <= upper);

    always_comb begin
        if (lower <= upper) hit = above_lo & below_hi;
        else                hit = above_lo | below_hi;
    end

endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
    import sar_seq_pkg::*;
#(
    parameter int W    = 8,
    parameter int CHW  = 3,
    parameter int GW   = 3,
    parameter int AW   = 2,
    parameter int DW   = 8,
    parameter int SYNC = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [AW-1:0]  cfg_addr,
    input  logic [DW-1:0]  cfg_wdata,
    input  logic           tmr_a_ovf,
    input  logic           tmr_b_ovf,
    input  logic           start_pin,
    input  logic           peer_go,
    input  logic           cmp_in,
    output logic           pwr_en,
    output logic           track_en,
    output logic [CHW-1:0] chan_sel,
    output logic [GW-1:0]  gain_sel,
    output logic [W-1:0]   dac_code,
    output logic [W-1:0]   result,
    output logic           busy,
    output logic           done,
    output logic           win_irq
);

    localparam int            BW      = $clog2(W);
    localparam logic [BW-1:0] MSB_IDX = BW'(W - 1);
    localparam logic [W-1:0]  MSB_ONE = W'(1) << (W - 1);

    sar_state_t     st_q, st_d;
    logic [BW-1:0]  bit_q;
    logic [W-1:0]   sar_q, result_q, conv_val;
    logic           en_q, done_q, win_q;
    logic [2:0]     mode_q;
    logic [CHW-1:0] chan_q;
    logic [GW-1:0]  gain_q;
    logic [W-1:0]   hi_q, lo_q;

    logic           ctl_wr, en_eff, sw_go, clr_done, clr_win;
    logic [2:0]     mode_eff;
    logic           trig, hit, conv_last;
    logic           unused_bits;

    assign ctl_wr      = cfg_we && (cfg_addr == AW'(0));
    assign en_eff      = ctl_wr ? cfg_wdata[0]   : en_q;
    assign mode_eff    = ctl_wr ? cfg_wdata[3:1] : mode_q;
    assign sw_go       = ctl_wr && cfg_wdata[4];
    assign clr_done    = ctl_wr && cfg_wdata[5];
    assign clr_win     = ctl_wr && cfg_wdata[6];
    assign unused_bits = cfg_wdata[DW-1];

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            mode_q <= SRC_SOFT;
            chan_q <= '0;
            gain_q <= GAIN_HALF;
            hi_q   <= '1;
            lo_q   <= '0;
        end else if (cfg_we) begin
            unique case (cfg_addr)
                AW'(0): begin
                    en_q   <= cfg_wdata[0];
                    mode_q <= cfg_wdata[3:1];
                end
                AW'(1): begin
                    chan_q <= cfg_wdata[CHW-1:0];
                    gain_q <= cfg_wdata[CHW+GW-1:CHW];
                end
                AW'(2):  hi_q <= cfg_wdata[W-1:0];
                default: lo_q <= cfg_wdata[W-1:0];
            endcase
        end
    end

    sar_seq_trig #(.SYNC(SYNC)) u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en_eff),
        .mode      (mode_eff),
        .sw_go     (sw_go),
        .tmr_a     (tmr_a_ovf),
        .tmr_b     (tmr_b_ovf),
        .pin_async (start_pin),
        .peer_go   (peer_go),
        .trig      (trig)
    );

    assign conv_val = {sar_q[W-1:1], cmp_in};

    sar_seq_win #(.W(W)) u_win (
        .value (conv_val),
        .upper (hi_q),
        .lower (lo_q),
        .hit   (hit)
    );

    assign conv_last = en_eff && (st_q == S_CONV) && (bit_q == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (!en_eff) begin
            st_d = S_IDLE;
        end else begin
            unique case (st_q)
                S_IDLE:  if (trig) st_d = S_TRACK;
                S_TRACK: st_d = S_CONV;
                S_CONV:  if (bit_q == '0) st_d = S_IDLE;
                default: st_d = S_IDLE;
            endcase
        end
    end

    // datapath and flag registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sar_q    <= '0;
            bit_q    <= '0;
            result_q <= '0;
            done_q   <= 1'b0;
            win_q    <= 1'b0;
        end else begin
            unique case (st_q)
                S_TRACK: begin
                    sar_q <= MSB_ONE;
                    bit_q <= MSB_IDX;
                end
                S_CONV: begin
                    sar_q[bit_q] <= cmp_in;
                    if (bit_q != '0) begin
                        sar_q[bit_q - 1'b1] <= 1'b1;
                        bit_q               <= bit_q - 1'b1;
                    end
                end
                default: ;
            endcase
            if (conv_last) result_q <= conv_val;
            if (conv_last)     done_q <= 1'b1;
            else if (clr_done) done_q <= 1'b0;
            if (conv_last && hit) win_q <= 1'b1;
            else if (clr_win)     win_q <= 1'b0;
        end
    end

    assign pwr_en   = en_q;
    assign track_en = (st_q == S_TRACK);
    assign busy     = (st_q != S_IDLE);
    assign chan_sel = chan_q;
    assign gain_sel = gain_q;
    assign dac_code = sar_q;
    assign result   = result_q;
    assign done     = done_q;
    assign win_irq  = win_q;

    AST_TRACK_TO_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        (track_en && en_eff) |=> (busy && !track_en && dac_code == MSB_ONE)); // R3
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_last |=> $stable(result)); // R4
    AST_BUSY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && en_eff && !conv_last) |=> busy); // R5
    AST_SHUTDOWN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en_eff |=> !busy); // R2
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clr_done) |=> done); // R6
    AST_WIN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (win_irq && !clr_win) |=> win_irq); // R9

endmodule

// File: tb/sar_seq_ctrl_test.sv
module sar_seq_ctrl_test;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       tmr_a_ovf = 1'b0, tmr_b_ovf = 1'b0, start_pin = 1'b0, peer_go = 1'b0;
    logic       cmp_in;
    logic       pwr_en, track_en, busy, done, win_irq;
    logic [2:0] chan_sel, gain_sel;
    logic [7:0] dac_code, result;
    logic [7:0] vin = '0;
    int         checks = 0;
    int         errors = 0;

    always #(CLK_P/2) clk = ~clk;

    assign cmp_in = (vin >= dac_code);

    sar_seq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .tmr_a_ovf(tmr_a_ovf), .tmr_b_ovf(tmr_b_ovf),
        .start_pin(start_pin), .peer_go(peer_go), .cmp_in(cmp_in),
        .pwr_en(pwr_en), .track_en(track_en), .chan_sel(chan_sel),
        .gain_sel(gain_sel), .dac_code(dac_code), .result(result),
        .busy(busy), .done(done), .win_irq(win_irq)
    );

    function automatic logic [7:0] ctl(input logic en, input logic [2:0] mode,
                                       input logic go, input logic cd, input logic cw);
        return {1'b0, cw, cd, go, mode, en};
    endfunction

    function automatic logic exp_win(input logic [7:0] r, input logic [7:0] hi,
                                     input logic [7:0] lo);
        if (lo <= hi) return (r >= lo) && (r <= hi);
        return (r <= hi) || (r >= lo);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 0) tmr_a_ovf = 1'b1;
        else if (which == 1) tmr_b_ovf = 1'b1;
        else peer_go = 1'b1;
        @(negedge clk);
        tmr_a_ovf = 1'b0; tmr_b_ovf = 1'b0; peer_go = 1'b0;
    endtask

    task automatic conv_sw(input logic [7:0] v);
        vin = v;
        wr(2'd0, ctl(1'b1, 3'b000, 1'b0, 1'b1, 1'b1));
        wr(2'd0, ctl(1'b1, 3'b000, 1'b1, 1'b0, 1'b0));
        repeat (9) @(negedge clk);
    endtask

    task automatic win_case(input logic [7:0] hi, input logic [7:0] lo,
                            input logic [7:0] v, input string tag);
        wr(2'd2, hi);
        wr(2'd3, lo);
        conv_sw(v);
        chk(tag, win_irq, exp_win(v, hi, lo));
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed_init;
        seed_init = $urandom(32'h1357);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk("R1 gain reset", gain_sel, 3'b000);
        chk("R1 chan reset", chan_sel, 0);
        chk("R2 pwr reset", pwr_en, 0);
        chk("R3 busy reset", busy, 0);
        chk("R6 done reset", done, 0);
        chk("R9 win reset", win_irq, 0);

        wr(2'd1, {2'b00, 3'b010, 3'b101});
        chk("R1 chan write", chan_sel, 5);
        chk("R1 gain write", gain_sel, 3'b010);

        // sequence timing, software start
        vin = 8'hA5;
        wr(2'd0, ctl(1'b1, 3'b000, 1'b1, 1'b0, 1'b0));
        chk("R3 busy after start", busy, 1);
        chk("R3 track cycle", track_en, 1);
        chk("R2 pwr on", pwr_en, 1);
        @(negedge clk);
        chk("R3 msb trial", dac_code, 8'h80);
        chk("R3 track end", track_en, 0);
        repeat (7) @(negedge clk);
        chk("R3 busy ninth cycle", busy, 1);
        chk("R6 done not yet", done, 0);
        @(negedge clk);
        chk("R3 busy end", busy, 0);
        chk("R4 result A5", result, 8'hA5);
        chk("R6 done set", done, 1);
        chk("R7 reset window hit", win_irq, 1);

        wr(2'd0, ctl(1'b1, 3'b000, 1'b0, 1'b1, 1'b0));
        chk("R6 done cleared", done, 0);
        chk("R9 win kept", win_irq, 1);
        wr(2'd0, ctl(1'b1, 3'b000, 1'b0, 1'b0, 1'b1));
        chk("R9 win cleared", win_irq, 0);

        conv_sw(8'h00); chk("R4 result 00", result, 8'h00);
        conv_sw(8'hFF); chk("R4 result FF", result, 8'hFF);
        conv_sw(8'h55); chk("R4 result 55", result, 8'h55);

        // timer A mode, ignored sources and busy re-trigger
        wr(2'd0, ctl(1'b1, 3'b001, 1'b1, 1'b1, 1'b1));
        chk("R10 soft ignored in mode 001", busy, 0);
        pulse(1);
        chk("R10 timer B ignored in mode 001", busy, 0);
        vin = 8'h3C;
        pulse(0);
        chk("R10 timer A starts", busy, 1);
        repeat (2) @(negedge clk);
        tmr_a_ovf = 1'b1;
        @(negedge clk);
        tmr_a_ovf = 1'b0;
        repeat (6) @(negedge clk);
        chk("R5 no extension", busy, 0);
        chk("R5 result intact", result, 8'h3C);
        @(negedge clk);
        chk("R5 no queued start", busy, 0);

        // timer B mode
        wr(2'd0, ctl(1'b1, 3'b011, 1'b0, 1'b1, 1'b1));
        vin = 8'hC3;
        pulse(1);
        chk("R10 timer B starts", busy, 1);
        repeat (9) @(negedge clk);
        chk("R10 timer B result", result, 8'hC3);

        // peer mode
        wr(2'd0, ctl(1'b1, 3'b110, 1'b0, 1'b1, 1'b1));
        pulse(0);
        chk("R10 timer A ignored in peer mode", busy, 0);
        vin = 8'h81;
        pulse(2);
        chk("R10 peer starts", busy, 1);
        repeat (9) @(negedge clk);
        chk("R10 peer result", result, 8'h81);

        // external pin
        wr(2'd0, ctl(1'b1, 3'b010, 1'b0, 1'b1, 1'b1));
        vin = 8'h7E;
        @(negedge clk); start_pin = 1'b1;
        @(negedge clk); chk("R11 not after 1 edge", busy, 0);
        @(negedge clk); chk("R11 not after 2 edges", busy, 0);
        @(negedge clk); chk("R11 busy after 3 edges", busy, 1);
        repeat (9) @(negedge clk);
        chk("R11 pin result", result, 8'h7E);
        repeat (3) @(negedge clk);
        chk("R11 held level no restart", busy, 0);
        start_pin = 1'b0;

        // disable
        wr(2'd0, ctl(1'b0, 3'b001, 1'b0, 1'b1, 1'b1));
        chk("R2 pwr off", pwr_en, 0);
        pulse(0);
        chk("R2 trigger ignored when off", busy, 0);
        wr(2'd0, ctl(1'b1, 3'b001, 1'b0, 1'b1, 1'b1));
        vin = 8'h11;
        pulse(0);
        repeat (2) @(negedge clk);
        wr(2'd0, ctl(1'b0, 3'b001, 1'b0, 1'b0, 1'b0));
        chk("R2 abort busy", busy, 0);
        repeat (10) @(negedge clk);
        chk("R2 abort no done", done, 0);

        // window corners
        win_case(8'h60, 8'h20, 8'h20, "R7 inside low edge");
        win_case(8'h60, 8'h20, 8'h60, "R7 inside high edge");
        win_case(8'h60, 8'h20, 8'h1F, "R7 below");
        win_case(8'h60, 8'h20, 8'h61, "R7 above");
        win_case(8'h40, 8'hC0, 8'h40, "R8 at upper");
        win_case(8'h40, 8'hC0, 8'hC0, "R8 at lower");
        win_case(8'h40, 8'hC0, 8'h80, "R8 between");
        win_case(8'h40, 8'hC0, 8'h41, "R8 just past upper");

        // sticky window across a miss
        wr(2'd2, 8'h10); wr(2'd3, 8'h00);
        vin = 8'h05;
        wr(2'd0, ctl(1'b1, 3'b000, 1'b1, 1'b1, 1'b1));
        repeat (9) @(negedge clk);
        vin = 8'h90;
        wr(2'd0, ctl(1'b1, 3'b000, 1'b1, 1'b1, 1'b0));
        repeat (9) @(negedge clk);
        chk("R9 win survives miss", win_irq, 1);

        // random
        for (int i = 0; i < 40; i++) begin
            logic [7:0] rh, rl, rv;
            rh = 8'($urandom); rl = 8'($urandom); rv = 8'($urandom);
            wr(2'd2, rh);
            wr(2'd3, rl);
            conv_sw(rv);
            chk("R4 random result", result, rv);
            chk("R6 random done", done, 1);
            chk((rl <= rh) ? "R7 random window" : "R8 random window",
                win_irq, exp_win(rv, rh, rl));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule